// File: doc/BRIEF.md
# Receive Lane Deskew Elastic Buffer

This block is the elastic buffer for one receive lane. Its write side runs on the lane's recovered clock and takes one word per accepted cycle: 32 decoded data bits, four flags that mark which bytes are control characters, and four alignment-marker flags. The read side runs on the fabric system clock and hands the stored 36-bit entries (control flags above data) to a consumer through a valid/ready port. The storage holds 24 entries. Write and read positions cross between the two clock domains as Gray-coded counts that run over twice the depth.

The marker flags are never stored. They are only used to start the lane. After reset, and after every resync request, the write side drops incoming words until a word arrives whose most significant byte carries an alignment marker. That word goes into entry 0. The read side then waits until half the buffer holds data before it offers anything, so the lane starts half full and has equal slack in both directions. The read-enable may come from a controller that groups several lanes or from simple local logic. Either way it drives `rd_ready`.

The write port has no ready signal, because a recovered-clock lane cannot be paused. A word presented when all 24 entries are in use is dropped. On the read port, an entry is transferred on each system-clock edge where `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, `rd_data` holds its value. A sticky overflow flag warns when the free space drops below a programmable minimum.

Top module: `dsk_lane_fifo`

## Requirements
- R1: After reset, `rd_valid` is 0 and `ovfl` is 0.
- R2: While waiting for alignment, accepted words with `wr_mark[3]` low are discarded. A word with only `wr_mark[2:0]` set does not start the lane. The first entry delivered is the word that carried `wr_mark[3]`.
- R3: Each delivered entry is `rd_data[35:32]` = the word's `wr_ctrl` and `rd_data[31:0]` = its `wr_data`. Entries come out in write order, each exactly once.
- R4: After alignment, `rd_valid` stays 0 until at least 12 words (half the depth) have been stored since the marker word, that word included.
- R5: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_data` does not change on the next edge.
- R6: Once aligned, `ovfl` goes to 1 when the number of free entries is less than `min_free`. It stays 1 until it is cleared.
- R7: A cycle with `ovfl_clr` high clears `ovfl`. A resync also clears it.
- R8: A word offered while all 24 entries are occupied is dropped. Entries already stored are kept and delivered unchanged.
- R9: A `resync` pulse drops `rd_valid` and discards all buffered words. The lane then waits for a new marker word, as in R2.
- R10: A cycle with `wr_valid` low stores nothing and does not align the lane, even if `wr_mark[3]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Lane recovered receive clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_valid | input | 1 | Word present on the write side this cycle |
| wr_data | input | 32 | Four decoded data bytes |
| wr_ctrl | input | 4 | Per-byte control-character flags |
| wr_mark | input | 4 | Per-byte alignment-marker flags; bit 3 (top byte) starts the lane |
| min_free | input | 5 | Minimum free entries before overflow is flagged |
| ovfl_clr | input | 1 | Clears the overflow flag (write domain) |
| ovfl | output | 1 | Sticky overflow status (write domain) |
| rd_clk | input | 1 | Fabric system clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| resync | input | 1 | One-cycle request (read domain) to re-align the lane |
| rd_ready | input | 1 | Consumer accepts the presented entry |
| rd_valid | output | 1 | An entry is presented |
| rd_data | output | 36 | Presented entry: control flags [35:32], data [31:0] |

## Verification
The start-up check feeds the buffer three kinds of input before the real marker: unmarked words, words marked only in the lower bytes, and an idle cycle with the top marker set. This separates an aligner that keys on the right flag and on `wr_valid` from one that does not. Eleven words after the marker leave the output silent and a twelfth releases it, which pins the half-full start to the exact count. A long stream with idle gaps and a consumer that accepts two of every three cycles tests order and stall holding. A phase with the consumer stopped moves the fill level just below the free-space threshold, then across it, then past full. This tells apart an off-by-one in the threshold compare, a full-buffer overwrite, and a loss of the sticky flag. A resync issued while a word is being presented checks that stale data is flushed.

// File: rtl/dsk_pkg.sv
package dsk_pkg;

  // Width of the generic Gray helpers; callers cast to their own width.
  localparam int GW = 16;

  typedef enum logic {
    WR_ARMED,
    WR_RUN
  } wr_state_e;

  typedef enum logic [1:0] {
    RD_WAIT_ACK,
    RD_FILL,
    RD_RUN
  } rd_state_e;

  function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dsk_sync.sv
module dsk_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= RST_VAL;
      stage2_q <= RST_VAL;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/dsk_store.sv
module dsk_store #(
  parameter int DEPTH = 24,
  parameter int W     = 36,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Asynchronous read; the read side only addresses entries whose write
  // has already been published through the synchronised pointer.
  assign rdata = mem[raddr];
endmodule

// File: rtl/dsk_wr_side.sv
module dsk_wr_side
  import dsk_pkg::*;
#(
  parameter int                DEPTH     = 24,
  parameter int                MARK_W    = 4,
  parameter logic [MARK_W-1:0] MARK_MASK = 4'b1000,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(2 * DEPTH),
  localparam int FREE_W = $clog2(DEPTH + 1)
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [MARK_W-1:0] wr_mark,
  input  logic [FREE_W-1:0] min_free,
  input  logic              ovfl_clr,
  input  logic              rq_tog_s,
  input  logic [CNT_W-1:0]  rptr_gray_s,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic [CNT_W-1:0]  wptr_gray,
  output logic              ack_tog,
  output logic              ovfl
);
  localparam int                OFF     = ((2 ** CNT_W) - 2 * DEPTH) / 2;
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(2 * DEPTH - 1);
  localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W:0]    TWO_D   = (CNT_W + 1)'(2 * DEPTH);
  localparam logic [FREE_W-1:0] FULL_C  = FREE_W'(DEPTH);
  localparam logic [CNT_W-1:0]  PTR_RST = CNT_W'(to_gray(GW'(OFF)));

  wr_state_e         state_q;
  logic [CNT_W-1:0]  wcnt_q, wcnt_nx, rcnt_s, wgray_q;
  logic [CNT_W:0]    diff;
  logic [FREE_W-1:0] occ, free;
  logic              seen_q, ack_q, ovfl_q;
  logic              rq_evt, mark_hit, full, accept;

  always_comb begin
    rq_evt   = (rq_tog_s != seen_q);
    rcnt_s   = CNT_W'(from_gray(GW'(rptr_gray_s)) - GW'(OFF));
    diff     = {1'b0, wcnt_q} + TWO_D - {1'b0, rcnt_s};
    if (diff >= TWO_D) diff = diff - TWO_D;
    occ      = FREE_W'(diff);
    full     = (occ == FULL_C);
    free     = FULL_C - occ;
    mark_hit = |(wr_mark & MARK_MASK);
    accept   = wr_valid && !rq_evt &&
               ((state_q == WR_ARMED) ? mark_hit : !full);
    wcnt_nx  = (wcnt_q == LAST) ? '0 : wcnt_q + 1'b1;
    mem_waddr = (wcnt_q >= DEPTH_C) ? AW'(wcnt_q - DEPTH_C) : AW'(wcnt_q);
  end

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      state_q <= WR_ARMED;
      wcnt_q  <= '0;
      wgray_q <= PTR_RST;
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      ovfl_q  <= 1'b0;
    end else begin
      seen_q <= rq_tog_s;
      // Acknowledge one cycle after the pointer reset has been published.
      ack_q  <= seen_q;
      if (rq_evt) begin
        state_q <= WR_ARMED;
        wcnt_q  <= '0;
        wgray_q <= PTR_RST;
        ovfl_q  <= 1'b0;
      end else begin
        if (accept) begin
          state_q <= WR_RUN;
          wcnt_q  <= wcnt_nx;
          wgray_q <= CNT_W'(to_gray(GW'(wcnt_nx) + GW'(OFF)));
        end
        if (ovfl_clr) ovfl_q <= 1'b0;
        else if (state_q == WR_RUN && free < min_free) ovfl_q <= 1'b1;
      end
    end
  end

  assign mem_we    = accept;
  assign wptr_gray = wgray_q;
  assign ack_tog   = ack_q;
  assign ovfl      = ovfl_q;

  // R8
  occ_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (state_q == WR_RUN) |-> (occ <= FULL_C));

  // R6
  ovfl_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (ovfl_q && !ovfl_clr && !rq_evt) |=> ovfl_q);

  // R2
  armed_wait_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (state_q == WR_ARMED && !(wr_valid && mark_hit)) |=>
      (state_q == WR_ARMED && wcnt_q == '0));
endmodule

// File: rtl/dsk_rd_side.sv
module dsk_rd_side
  import dsk_pkg::*;
#(
  parameter int DEPTH = 24,
  parameter int W     = 36,
  localparam int AW     = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(2 * DEPTH),
  localparam int FREE_W = $clog2(DEPTH + 1)
) (
  input  logic             rd_clk,
  input  logic             rd_rst_n,
  input  logic             resync,
  input  logic             rd_ready,
  input  logic [CNT_W-1:0] wptr_gray_s,
  input  logic             ack_tog_s,
  input  logic [W-1:0]     mem_rdata,
  output logic [AW-1:0]    mem_raddr,
  output logic [CNT_W-1:0] rptr_gray,
  output logic             rq_tog,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data
);
  localparam int                OFF     = ((2 ** CNT_W) - 2 * DEPTH) / 2;
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(2 * DEPTH - 1);
  localparam logic [CNT_W-1:0]  DEPTH_C = CNT_W'(DEPTH);
  localparam logic [CNT_W:0]    TWO_D   = (CNT_W + 1)'(2 * DEPTH);
  localparam logic [FREE_W-1:0] HALF_C  = FREE_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0]  PTR_RST = CNT_W'(to_gray(GW'(OFF)));

  rd_state_e         state_q;
  logic [CNT_W-1:0]  rcnt_q, rcnt_nx, wcnt_s, rgray_q;
  logic [CNT_W:0]    diff;
  logic [FREE_W-1:0] occ;
  logic              tog_q, valid_q, load;
  logic [W-1:0]      data_q;

  always_comb begin
    wcnt_s  = CNT_W'(from_gray(GW'(wptr_gray_s)) - GW'(OFF));
    diff    = {1'b0, wcnt_s} + TWO_D - {1'b0, rcnt_q};
    if (diff >= TWO_D) diff = diff - TWO_D;
    occ     = FREE_W'(diff);
    load    = (state_q == RD_RUN) && (occ != '0) && (!valid_q || rd_ready);
    rcnt_nx = (rcnt_q == LAST) ? '0 : rcnt_q + 1'b1;
    mem_raddr = (rcnt_q >= DEPTH_C) ? AW'(rcnt_q - DEPTH_C) : AW'(rcnt_q);
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      state_q <= RD_FILL;
      rcnt_q  <= '0;
      rgray_q <= PTR_RST;
      tog_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (resync) begin
      tog_q   <= ~tog_q;
      state_q <= RD_WAIT_ACK;
      rcnt_q  <= '0;
      rgray_q <= PTR_RST;
      valid_q <= 1'b0;
    end else begin
      case (state_q)
        RD_WAIT_ACK: if (ack_tog_s == tog_q) state_q <= RD_FILL;
        RD_FILL:     if (occ >= HALF_C) state_q <= RD_RUN;
        default:     ;
      endcase
      if (load) begin
        data_q  <= mem_rdata;
        valid_q <= 1'b1;
        rcnt_q  <= rcnt_nx;
        rgray_q <= CNT_W'(to_gray(GW'(rcnt_nx) + GW'(OFF)));
      end else if (rd_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rptr_gray = rgray_q;
  assign rq_tog    = tog_q;
  assign rd_valid  = valid_q;
  assign rd_data   = data_q;

  // R5
  hold_stable_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n || resync)
    (valid_q && !rd_ready) |=> (valid_q && $stable(data_q)));

  // R9
  run_gate_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (state_q != RD_RUN) |-> !valid_q);

  // R4
  fill_gate_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (state_q == RD_FILL && !resync && occ < HALF_C) |=> (state_q == RD_FILL));
endmodule

// File: rtl/dsk_lane_fifo.sv
module dsk_lane_fifo
  import dsk_pkg::*;
#(
  parameter int                DEPTH     = 24,
  parameter int                DATA_W    = 32,
  parameter int                BYTES     = 4,
  parameter int                MARK_W    = 4,
  parameter logic [MARK_W-1:0] MARK_MASK = 4'b1000
) (
  input  logic                           wr_clk,
  input  logic                           wr_rst_n,
  input  logic                           wr_valid,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [BYTES-1:0]               wr_ctrl,
  input  logic [MARK_W-1:0]              wr_mark,
  input  logic [$clog2(DEPTH+1)-1:0]     min_free,
  input  logic                           ovfl_clr,
  output logic                           ovfl,
  input  logic                           rd_clk,
  input  logic                           rd_rst_n,
  input  logic                           resync,
  input  logic                           rd_ready,
  output logic                           rd_valid,
  output logic [DATA_W+BYTES-1:0]        rd_data
);
  localparam int ENT_W = DATA_W + BYTES;
  localparam int AW    = $clog2(DEPTH);
  localparam int CNT_W = $clog2(2 * DEPTH);
  localparam int OFF   = ((2 ** CNT_W) - 2 * DEPTH) / 2;
  localparam logic [CNT_W-1:0] PTR_RST = CNT_W'(to_gray(GW'(OFF)));

  logic             mem_we;
  logic [AW-1:0]    mem_waddr, mem_raddr;
  logic [ENT_W-1:0] mem_rdata;
  logic [CNT_W-1:0] wptr_gray, wptr_gray_s, rptr_gray, rptr_gray_s;
  logic             ack_tog, ack_tog_s, rq_tog, rq_tog_s;

  dsk_wr_side #(.DEPTH(DEPTH), .MARK_W(MARK_W), .MARK_MASK(MARK_MASK)) u_wr (
    .wr_clk      (wr_clk),
    .wr_rst_n    (wr_rst_n),
    .wr_valid    (wr_valid),
    .wr_mark     (wr_mark),
    .min_free    (min_free),
    .ovfl_clr    (ovfl_clr),
    .rq_tog_s    (rq_tog_s),
    .rptr_gray_s (rptr_gray_s),
    .mem_we      (mem_we),
    .mem_waddr   (mem_waddr),
    .wptr_gray   (wptr_gray),
    .ack_tog     (ack_tog),
    .ovfl        (ovfl)
  );

  dsk_store #(.DEPTH(DEPTH), .W(ENT_W)) u_store (
    .wr_clk (wr_clk),
    .we     (mem_we),
    .waddr  (mem_waddr),
    .wdata  ({wr_ctrl, wr_data}),
    .raddr  (mem_raddr),
    .rdata  (mem_rdata)
  );

  dsk_rd_side #(.DEPTH(DEPTH), .W(ENT_W)) u_rd (
    .rd_clk      (rd_clk),
    .rd_rst_n    (rd_rst_n),
    .resync      (resync),
    .rd_ready    (rd_ready),
    .wptr_gray_s (wptr_gray_s),
    .ack_tog_s   (ack_tog_s),
    .mem_rdata   (mem_rdata),
    .mem_raddr   (mem_raddr),
    .rptr_gray   (rptr_gray),
    .rq_tog      (rq_tog),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data)
  );

  dsk_sync #(.W(CNT_W), .RST_VAL(PTR_RST)) u_sync_wptr (
    .clk (rd_clk), .rst_n (rd_rst_n), .d (wptr_gray), .q (wptr_gray_s)
  );

  dsk_sync #(.W(1), .RST_VAL(1'b0)) u_sync_ack (
    .clk (rd_clk), .rst_n (rd_rst_n), .d (ack_tog), .q (ack_tog_s)
  );

  dsk_sync #(.W(CNT_W), .RST_VAL(PTR_RST)) u_sync_rptr (
    .clk (wr_clk), .rst_n (wr_rst_n), .d (rptr_gray), .q (rptr_gray_s)
  );

  dsk_sync #(.W(1), .RST_VAL(1'b0)) u_sync_rq (
    .clk (wr_clk), .rst_n (wr_rst_n), .d (rq_tog), .q (rq_tog_s)
  );
endmodule

// File: tb/test_dsk_lane_fifo.sv
module test_dsk_lane_fifo;
  localparam int DEPTH = 24;
  localparam int HALF  = 12;

  logic        wr_clk = 1'b0, rd_clk = 1'b0;
  logic        wr_rst_n, rd_rst_n;
  logic        wr_valid;
  logic [31:0] wr_data;
  logic [3:0]  wr_ctrl, wr_mark;
  logic [4:0]  min_free;
  logic        ovfl_clr, ovfl, resync, rd_ready, rd_valid;
  logic [35:0] rd_data;

  always #3 wr_clk = ~wr_clk;
  always #2 rd_clk = ~rd_clk;   // 250 MHz system clock

  dsk_lane_fifo i_dsk_lane_fifo (
    .wr_clk, .wr_rst_n, .wr_valid, .wr_data, .wr_ctrl, .wr_mark,
    .min_free, .ovfl_clr, .ovfl, .rd_clk, .rd_rst_n, .resync,
    .rd_ready, .rd_valid, .rd_data
  );

  // Reference model state
  logic [35:0] q[$];
  bit          armed, started, skip_hold, prev_hold, run_on;
  logic [35:0] prev_data;
  int          wr_since, ready_mode, rcyc;
  int          errors = 0, checks = 0;
  string       cur_tag = "R3";

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic put(input bit v, input logic [31:0] d, input logic [3:0] c, input logic [3:0] m);
    @(negedge wr_clk);
    wr_valid = v; wr_data = d; wr_ctrl = c; wr_mark = m;
    if (v) begin
      if (armed) begin
        if (m[3]) begin armed = 0; q.push_back({c, d}); wr_since = 1; end
      end else if (q.size() < DEPTH + 1) begin
        q.push_back({c, d}); wr_since++;
      end
    end
  endtask

  task automatic idle_w(input int n);
    repeat (n) @(negedge wr_clk) wr_valid = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int n = 0;
    while (q.size() != 0 && n < 3000) begin @(negedge rd_clk); n++; end
    repeat (6) @(negedge rd_clk);
    chk(q.size() == 0, tag, q.size(), 0);
  endtask

  // Consumer side: drives rd_ready and compares every transfer to the model
  always @(negedge rd_clk) begin
    if (run_on) begin
      if (prev_hold && !skip_hold)
        chk(rd_valid && rd_data == prev_data, "R5", {rd_valid, rd_data}, {1'b1, prev_data});
      rcyc++;
      case (ready_mode)
        0: rd_ready = 1'b0;
        1: rd_ready = 1'b1;
        default: rd_ready = (rcyc % 3 != 0);
      endcase
      if (rd_valid && !started && !skip_hold) begin
        started = 1;
        chk(wr_since >= HALF, "R4", wr_since, HALF);
      end
      if (rd_valid && rd_ready) begin
        if (q.size() == 0) chk(1'b0, cur_tag, rd_data, 0);
        else begin
          logic [35:0] e;
          e = q.pop_front();
          chk(rd_data == e, cur_tag, rd_data, e);
        end
      end
      prev_hold = rd_valid && !rd_ready;
      prev_data = rd_data;
    end
  end

  initial begin
    repeat (150000) @(posedge rd_clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    wr_rst_n = 0; rd_rst_n = 0; wr_valid = 0; wr_data = '0; wr_ctrl = '0; wr_mark = '0;
    min_free = 5'd4; ovfl_clr = 0; resync = 0; rd_ready = 0;
    armed = 1; started = 0; skip_hold = 1; prev_hold = 0; run_on = 0;
    wr_since = 0; ready_mode = 0; rcyc = 0;
    repeat (5) @(negedge rd_clk);
    wr_rst_n = 1; rd_rst_n = 1;
    repeat (4) @(negedge rd_clk);
    // R1
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    chk(ovfl == 1'b0, "R1", ovfl, 0);
    skip_hold = 0; run_on = 1;

    // R2 / R10: pre-marker words, low-byte markers, idle cycle with top marker
    cur_tag = "R2";
    put(1, 32'hDEAD_0001, 4'h0, 4'b0000);
    put(1, 32'hDEAD_0002, 4'h1, 4'b0111);
    put(1, 32'hDEAD_0003, 4'h2, 4'b0001);
    put(0, 32'hBAD0_0BAD, 4'hF, 4'b1000);   // R10: not valid, ignored
    put(1, 32'hA5A5_0000, 4'b1000, 4'b1000);
    for (int i = 1; i <= 10; i++) put(1, 32'h1000 + i, 4'(i), 4'b0000);
    idle_w(5);
    ready_mode = 1;
    repeat (30) @(negedge rd_clk);
    chk(rd_valid == 1'b0, "R4", rd_valid, 0);   // only 11 stored so far

    // R3: long stream with gaps, consumer at two of three cycles
    ready_mode = 2;
    put(1, 32'h1000_000B, 4'h3, 4'b0000);
    cur_tag = "R3";
    for (int i = 0; i < 40; i++) begin
      if (i % 4 == 3) put(0, 32'hFFFF_FFFF, 4'hF, 4'b1000);
      else put(1, 32'h2000_0000 + i * 32'h0101_0101, 4'(i % 16), 4'(i % 8));
    end
    idle_w(5);
    wait_drain("R3");
    chk(ovfl == 1'b0, "R6", ovfl, 0);

    // R6: fill just to threshold, then past it
    ready_mode = 0; min_free = 5'd8;
    idle_w(3);
    for (int i = 0; i < 17; i++) put(1, 32'h3000_0000 + i, 4'hF, 4'b0000);
    idle_w(20);
    chk(ovfl == 1'b0, "R6", ovfl, 0);   // 16 held, 8 free
    put(1, 32'h3000_0100, 4'h6, 4'b0000);
    put(1, 32'h3000_0101, 4'h7, 4'b0000);
    idle_w(10);
    chk(ovfl == 1'b1, "R6", ovfl, 1);   // 18 held, 6 free

    // R8: keep writing past full, then drain
    for (int i = 0; i < 10; i++) put(1, 32'h4000_0000 + i, 4'h5, 4'b0000);
    idle_w(10);
    cur_tag = "R8";
    ready_mode = 1;
    wait_drain("R8");
    chk(ovfl == 1'b1, "R6", ovfl, 1);   // sticky after drain

    // R7: explicit clear
    @(negedge wr_clk) ovfl_clr = 1;
    @(negedge wr_clk) ovfl_clr = 0;
    idle_w(3);
    chk(ovfl == 1'b0, "R7", ovfl, 0);

    // Set ovfl again to see resync clear it
    cur_tag = "R3";
    min_free = 5'd24;
    put(1, 32'h5000_0000, 4'h1, 4'b0000);
    idle_w(10);
    chk(ovfl == 1'b1, "R6", ovfl, 1);
    wait_drain("R3");
    min_free = 5'd4;

    // R9: resync while a word is being presented
    ready_mode = 0;
    for (int i = 0; i < 3; i++) put(1, 32'h6000_0000 + i, 4'h2, 4'b0000);
    idle_w(12);
    chk(rd_valid == 1'b1, "R9", rd_valid, 1);
    skip_hold = 1;
    @(negedge rd_clk);
    resync = 1; q.delete(); armed = 1; wr_since = 0; started = 0;
    @(negedge rd_clk) resync = 0;
    repeat (3) @(negedge rd_clk);
    chk(rd_valid == 1'b0, "R9", rd_valid, 0);
    idle_w(10);
    chk(ovfl == 1'b0, "R7", ovfl, 0);
    skip_hold = 0;

    cur_tag = "R9";
    put(1, 32'h7777_0001, 4'h0, 4'b0000);
    put(1, 32'h7777_0002, 4'h0, 4'b0100);
    put(1, 32'hC3C3_0000, 4'b1001, 4'b1100);
    ready_mode = 1;
    for (int i = 0; i < 29; i++) put(1, 32'h8000_0000 + i, 4'(i), 4'b0000);
    idle_w(5);
    wait_drain("R9");

    finish_run();
  end
endmodule